// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Arbiter

This block decides when a two-channel serial controller interrupts its host and what it reports about the cause. Each channel can raise a receive request when a byte arrives and a transmit request when the host writes a byte. The block tracks which request is currently being serviced. Receive requests pre-empt transmit requests, and while a receive is under service a new transmit request is only recorded, not promoted. The block keeps a pending register that covers both channels and a single shared interrupt vector. The vector's encoding switches between a status-high and a status-low form.

The host's data-port reads and writes reach the block as one-cycle strobes, and so do its two control commands: reset-highest-under-service and clear-transmit-pending. The enable bits reach it as plain levels. All of these are plain control pins; the block has no streaming interface, so no back-pressure applies. Every strobe that arrives in a cycle is applied on the next rising edge. The strobes are applied in a fixed order: first the commands and reads that clear, then the transmit raises, then the receive raises. The interrupt output is then evaluated from the resulting state and registered.

Top module: `sio_irq_arbiter`

## Requirements
- R1: After reset, irq is 0, int_pend is 0x00, rx_ius and tx_ius are 0, and int_vec is 0x06.
- R2: irq, one cycle after its inputs, is the OR over both channels of three terms. The terms are: transmit pending with tx_ie set; receive pending with that channel's rx_mode field equal to 01 or 10; and brk_ie and brk_stat both set. rx_mode values 00 and 11 give no receive request.
- R3: An rx_avail strobe marks receive pending and receive-under-service for that channel. It sets that channel's receive pending bit and loads the receive vector of that channel.
- R4: A wr_data strobe marks transmit pending. If that channel has no receive under service, it also sets transmit-under-service and loads the transmit vector. The transmit pending bit is set only when tx_ie is 1. If a receive is under service, nothing beyond the pending flag changes.
- R5: cmd_rst_ius clears receive-under-service if it is set and re-raises a still-pending transmit as in R4. Otherwise it clears transmit-under-service.
- R6: cmd_clr_tx clears transmit pending, transmit-under-service and the transmit pending bit. It loads the "none" vector, then re-raises a still-pending receive as in R3.
- R7: rd_data clears receive pending, receive-under-service and the receive pending bit. It loads the "none" vector, then re-raises a still-pending transmit as in R4.
- R8: Vector codes with stat_hi=1 are: none 0x60, rx A 0x30, rx B 0x20, tx A 0x10, tx B 0x00. With stat_hi=0 they are: none 0x06, rx A 0x0C, rx B 0x04, tx A 0x08, tx B 0x00.
- R9: int_pend uses these bit positions: ext B bit 0, tx B bit 1, rx B bit 2, ext A bit 3, tx A bit 4, rx A bit 5. Bits 7:6 are 0. Each ext bit is brk_ie AND brk_stat of its channel, registered. Channel A is index 0 of every two-bit port and channel B is index 1. rx_mode[1:0] belongs to A and rx_mode[3:2] to B.
- R10: Strobes that coincide are applied in this order: clears (channel B, then A; within a channel reset-under-service, then clear-tx, then read), then transmit raises (B, then A), then receive raises (B, then A). The last vector load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_hi | input | 1 | Selects the status-high vector encoding |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode per channel, two bits each |
| brk_ie | input | 2 | Break interrupt enable per channel |
| brk_stat | input | 2 | Break status per channel |
| rx_avail | input | 2 | Receive byte arrived strobe |
| rd_data | input | 2 | Host data-port read strobe |
| wr_data | input | 2 | Host data-port write strobe |
| cmd_rst_ius | input | 2 | Reset-highest-under-service command strobe |
| cmd_clr_tx | input | 2 | Clear-transmit-pending command strobe |
| irq | output | 1 | Combined interrupt request |
| int_vec | output | 8 | Shared interrupt vector |
| int_pend | output | 8 | Interrupt pending register |
| rx_ius | output | 2 | Receive under service per channel |
| tx_ius | output | 2 | Transmit under service per channel |

## Verification
Two situations can fall in the same cycle. In the first, a receive raise on one channel meets a transmit raise on the other. In the second, a data read meets a new byte arrival on the same channel. Both are provoked by driving the two strobes together. The bench then judges the vector, the pending bits and the under-service flags against the R10 order. In the first case the receive vector of channel A must win. In the second, receive-under-service must stay set because the raise follows the clear.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int unsigned CH_N   = 2;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned PEND_W = 8;
  localparam int unsigned PST_W  = 3 * CH_N;

  typedef enum logic [1:0] {
    VK_NONE = 2'd0,
    VK_RX   = 2'd1,
    VK_TX   = 2'd2
  } vec_kind_e;

  typedef struct packed {
    logic rxp;
    logic txp;
    logic rxius;
    logic txius;
  } chn_st_t;

  typedef struct packed {
    chn_st_t [CH_N-1:0] ch;
    logic [PST_W-1:0]   pend;
    logic [VEC_W-1:0]   vec;
  } arb_st_t;

  localparam logic [VEC_W-1:0] VEC_RESET = 8'h06;

  // Channel A (index 0) owns the upper three pending bits.
  function automatic int pend_base(input int c);
    return (c == 0) ? 3 : 0;
  endfunction

  function automatic logic [VEC_W-1:0] vec_code(input vec_kind_e kind,
                                                input logic chb,
                                                input logic hi);
    logic [VEC_W-1:0] v;
    case (kind)
      VK_RX:   v = chb ? (hi ? 8'h20 : 8'h04) : (hi ? 8'h30 : 8'h0C);
      VK_TX:   v = chb ? 8'h00 : (hi ? 8'h10 : 8'h08);
      default: v = hi ? 8'h60 : 8'h06;
    endcase
    return v;
  endfunction

  function automatic arb_st_t raise_rx(input arb_st_t s, input int c,
                                       input logic hi);
    arb_st_t r;
    r = s;
    r.ch[c].rxp   = 1'b1;
    r.ch[c].rxius = 1'b1;
    r.pend[pend_base(c) + 2] = 1'b1;
    r.vec = vec_code(VK_RX, (c != 0), hi);
    return r;
  endfunction

  function automatic arb_st_t raise_tx(input arb_st_t s, input int c,
                                       input logic hi, input logic ie);
    arb_st_t r;
    r = s;
    r.ch[c].txp = 1'b1;
    if (!r.ch[c].rxius) begin
      r.ch[c].txius = 1'b1;
      if (ie) r.pend[pend_base(c) + 1] = 1'b1;
      r.vec = vec_code(VK_TX, (c != 0), hi);
    end
    return r;
  endfunction

  function automatic arb_st_t drop_rx(input arb_st_t s, input int c,
                                      input logic hi, input logic ie);
    arb_st_t r;
    r = s;
    r.ch[c].rxp   = 1'b0;
    r.ch[c].rxius = 1'b0;
    r.pend[pend_base(c) + 2] = 1'b0;
    r.vec = vec_code(VK_NONE, (c != 0), hi);
    if (r.ch[c].txp) r = raise_tx(r, c, hi, ie);
    return r;
  endfunction

  function automatic arb_st_t drop_tx(input arb_st_t s, input int c,
                                      input logic hi);
    arb_st_t r;
    r = s;
    r.ch[c].txp   = 1'b0;
    r.ch[c].txius = 1'b0;
    r.pend[pend_base(c) + 1] = 1'b0;
    r.vec = vec_code(VK_NONE, (c != 0), hi);
    if (r.ch[c].rxp) r = raise_rx(r, c, hi);
    return r;
  endfunction

  function automatic arb_st_t release_ius(input arb_st_t s, input int c,
                                          input logic hi, input logic ie);
    arb_st_t r;
    r = s;
    if (r.ch[c].rxius) begin
      r.ch[c].rxius = 1'b0;
      if (r.ch[c].txp) r = raise_tx(r, c, hi, ie);
    end else begin
      r.ch[c].txius = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/sio_irq_req.sv
module sio_irq_req (
  input  logic       txp,
  input  logic       rxp,
  input  logic       tx_en,
  input  logic [1:0] rx_md,
  input  logic       brk_en,
  input  logic       brk,
  output logic       req,
  output logic       ext
);
  logic rx_en;

  always_comb begin
    rx_en = (rx_md == 2'b01) || (rx_md == 2'b10);
    ext   = brk_en & brk;
    req   = (tx_en & txp) | (rx_en & rxp) | ext;
  end
endmodule

// File: rtl/sio_irq_next.sv
module sio_irq_next
  import sio_irq_pkg::*;
(
  input  arb_st_t         cur,
  input  logic            hi,
  input  logic [CH_N-1:0] tx_en,
  input  logic [CH_N-1:0] ev_rx,
  input  logic [CH_N-1:0] ev_rd,
  input  logic [CH_N-1:0] ev_wr,
  input  logic [CH_N-1:0] ev_rst,
  input  logic [CH_N-1:0] ev_clr,
  output arb_st_t         nxt
);
  always_comb begin
    arb_st_t s;
    s = cur;
    // Phase 1: clearing strobes, channel B first.
    for (int c = CH_N - 1; c >= 0; c--) begin
      if (ev_rst[c]) s = release_ius(s, c, hi, tx_en[c]);
      if (ev_clr[c]) s = drop_tx(s, c, hi);
      if (ev_rd[c])  s = drop_rx(s, c, hi, tx_en[c]);
    end
    // Phase 2: transmit raises.
    for (int c = CH_N - 1; c >= 0; c--) begin
      if (ev_wr[c]) begin
        s.ch[c].txp = 1'b0;
        s = raise_tx(s, c, hi, tx_en[c]);
      end
    end
    // Phase 3: receive raises last, so they win the vector.
    for (int c = CH_N - 1; c >= 0; c--) begin
      if (ev_rx[c]) s = raise_rx(s, c, hi);
    end
    nxt = s;
  end
endmodule

// File: rtl/sio_irq_arbiter.sv
module sio_irq_arbiter
  import sio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_hi,
  input  logic [1:0]        tx_ie,
  input  logic [3:0]        rx_mode,
  input  logic [1:0]        brk_ie,
  input  logic [1:0]        brk_stat,
  input  logic [1:0]        rx_avail,
  input  logic [1:0]        rd_data,
  input  logic [1:0]        wr_data,
  input  logic [1:0]        cmd_rst_ius,
  input  logic [1:0]        cmd_clr_tx,
  output logic              irq,
  output logic [VEC_W-1:0]  int_vec,
  output logic [PEND_W-1:0] int_pend,
  output logic [1:0]        rx_ius,
  output logic [1:0]        tx_ius
);
  arb_st_t         st_q;
  arb_st_t         st_d;
  logic [CH_N-1:0] req;
  logic [CH_N-1:0] ext;
  logic [CH_N-1:0] ext_q;
  logic            irq_q;

  sio_irq_next u_next (
    .cur    (st_q),
    .hi     (stat_hi),
    .tx_en  (tx_ie),
    .ev_rx  (rx_avail),
    .ev_rd  (rd_data),
    .ev_wr  (wr_data),
    .ev_rst (cmd_rst_ius),
    .ev_clr (cmd_clr_tx),
    .nxt    (st_d)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    sio_irq_req u_req (
      .txp    (st_d.ch[c].txp),
      .rxp    (st_d.ch[c].rxp),
      .tx_en  (tx_ie[c]),
      .rx_md  (rx_mode[2*c +: 2]),
      .brk_en (brk_ie[c]),
      .brk    (brk_stat[c]),
      .req    (req[c]),
      .ext    (ext[c])
    );
    assign rx_ius[c] = st_q.ch[c].rxius;
    assign tx_ius[c] = st_q.ch[c].txius;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= '0;
      st_q.vec <= VEC_RESET;
      ext_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      st_q  <= st_d;
      ext_q <= ext;
      irq_q <= |req;
    end
  end

  assign irq      = irq_q;
  assign int_vec  = st_q.vec;
  assign int_pend = {2'b00, st_q.pend | {ext_q[0], 2'b00, ext_q[1]} << 0};
endmodule

// File: rtl/sio_irq_arbiter_chk.sv
module sio_irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_hi,
  input logic [1:0] tx_ie,
  input logic [3:0] rx_mode,
  input logic [1:0] brk_ie,
  input logic [1:0] brk_stat,
  input logic [1:0] rx_avail,
  input logic [1:0] rd_data,
  input logic [1:0] wr_data,
  input logic [1:0] cmd_rst_ius,
  input logic [1:0] cmd_clr_tx,
  input logic       irq,
  input logic [7:0] int_vec,
  input logic [7:0] int_pend,
  input logic [1:0] rx_ius,
  input logic [1:0] tx_ius
);
  // R8
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_vec inside {8'h60, 8'h30, 8'h20, 8'h10, 8'h00,
                    8'h06, 8'h0C, 8'h04, 8'h08});

  // R9
  pend_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_pend[7:6] == 2'b00);

  for (genvar c = 0; c < 2; c++) begin : g_chk
    // R3
    rx_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_avail[c] |=> rx_ius[c] && int_pend[(c == 0) ? 5 : 2]);

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ius[c] && !cmd_rst_ius[c] && !rd_data[c] && !cmd_clr_tx[c])
        |=> !$rose(tx_ius[c]));

    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[c] && !rx_avail[c]) |=> !rx_ius[c]);

    // R5
    ius_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rst_ius[c] && rx_ius[c] && !rx_avail[c] && !cmd_clr_tx[c])
        |=> !rx_ius[c]);

    // R6
    clr_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_clr_tx[c] && !wr_data[c]) |=> !tx_ius[c]);
  end
endmodule

bind sio_irq_arbiter sio_irq_arbiter_chk u_chk (.*);

// File: tb/sio_irq_arbiter_bench.sv
`timescale 1ns/100ps
module sio_irq_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stat_hi = 1'b0;
  logic [1:0] tx_ie = 2'b11;
  logic [3:0] rx_mode = 4'b0101;
  logic [1:0] brk_ie = 2'b00;
  logic [1:0] brk_stat = 2'b00;
  logic [1:0] rx_avail = '0, rd_data = '0, wr_data = '0;
  logic [1:0] cmd_rst_ius = '0, cmd_clr_tx = '0;
  logic       irq;
  logic [7:0] int_vec, int_pend;
  logic [1:0] rx_ius, tx_ius;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic       irq;
    logic [7:0] vec;
    logic [7:0] pend;
    logic [1:0] rxi;
    logic [1:0] txi;
    int         due;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sio_irq_arbiter u_sio_irq_arbiter (.*);

  task automatic step(input logic [1:0] e_rx, input logic [1:0] e_rd,
                      input logic [1:0] e_wr, input logic [1:0] e_rst,
                      input logic [1:0] e_clr, input logic x_irq,
                      input logic [7:0] x_vec, input logic [7:0] x_pend,
                      input logic [1:0] x_rxi, input logic [1:0] x_txi,
                      input string tag);
    exp_t e;
    @(posedge clk); #1;
    rx_avail = e_rx; rd_data = e_rd; wr_data = e_wr;
    cmd_rst_ius = e_rst; cmd_clr_tx = e_clr;
    e.irq = x_irq; e.vec = x_vec; e.pend = x_pend;
    e.rxi = x_rxi; e.txi = x_txi; e.due = cyc + 1; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    rx_avail = '0; rd_data = '0; wr_data = '0;
    cmd_rst_ius = '0; cmd_clr_tx = '0;
  endtask

  // Monitor: pops expected items when they fall due.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (irq !== e.irq || int_vec !== e.vec || int_pend !== e.pend ||
            rx_ius !== e.rxi || tx_ius !== e.txi) begin
          errors++;
          $display("FAIL %s: got irq=%0b vec=%02h pend=%02h rxi=%02b txi=%02b, expected irq=%0b vec=%02h pend=%02h rxi=%02b txi=%02b",
                   e.tag, irq, int_vec, int_pend, rx_ius, tx_ius,
                   e.irq, e.vec, e.pend, e.rxi, e.txi);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got no end of test, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    //   rx     rd     wr     rst    clr    irq vec    pend   rxi    txi
    step(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 0, 8'h06, 8'h00, 2'b00, 2'b00, "R1 reset state");
    step(2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 1, 8'h08, 8'h10, 2'b00, 2'b01, "R4 tx raise A");
    step(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 1, 8'h0C, 8'h30, 2'b01, 2'b01, "R3 rx raise A");
    step(2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 1, 8'h08, 8'h10, 2'b00, 2'b01, "R7 read re-raises tx A");
    step(2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 0, 8'h06, 8'h00, 2'b00, 2'b00, "R6 clear tx A");
    step(2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 1, 8'h04, 8'h04, 2'b10, 2'b00, "R3 rx raise B");
    step(2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 1, 8'h04, 8'h04, 2'b10, 2'b00, "R4 tx held off by rx B");
    step(2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 1, 8'h00, 8'h06, 2'b00, 2'b10, "R5 release rx, promote tx B");
    step(2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 1, 8'h00, 8'h06, 2'b00, 2'b00, "R5 release tx B");
    step(2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 1, 8'h00, 8'h02, 2'b00, 2'b10, "R7 read B re-raises tx");
    step(2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 0, 8'h06, 8'h00, 2'b00, 2'b00, "R6 clear tx B");
    step(2'b01, 2'b00, 2'b10, 2'b00, 2'b00, 1, 8'h0C, 8'h22, 2'b01, 2'b10, "R10 rx A beats tx B");
    step(2'b01, 2'b01, 2'b00, 2'b00, 2'b00, 1, 8'h0C, 8'h22, 2'b01, 2'b10, "R10 read then arrival A");
    step(2'b00, 2'b01, 2'b00, 2'b00, 2'b10, 0, 8'h06, 8'h00, 2'b00, 2'b00, "R10 two clears together");
    stat_hi = 1'b1;
    step(2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 1, 8'h20, 8'h04, 2'b10, 2'b00, "R8 high rx B");
    step(2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 1, 8'h10, 8'h14, 2'b10, 2'b01, "R8 high tx A");
    step(2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 1, 8'h60, 8'h10, 2'b00, 2'b01, "R8 high none");
    step(2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 0, 8'h60, 8'h00, 2'b00, 2'b00, "R6 clear tx A high");
    tx_ie = 2'b10;
    step(2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 0, 8'h10, 8'h00, 2'b00, 2'b01, "R9 tx bit gated by enable");
    step(2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 0, 8'h60, 8'h00, 2'b00, 2'b00, "R6 clear gated tx");
    tx_ie = 2'b11; rx_mode = 4'b0111;
    step(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 0, 8'h30, 8'h20, 2'b01, 2'b00, "R2 mode 11 gives no irq");
    rx_mode = 4'b0110;
    step(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1, 8'h30, 8'h20, 2'b01, 2'b00, "R2 mode 10 gives irq");
    step(2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 0, 8'h60, 8'h00, 2'b00, 2'b00, "R7 read A idle tx");
    brk_ie = 2'b10; brk_stat = 2'b10;
    step(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1, 8'h60, 8'h01, 2'b00, 2'b00, "R9 break B ext bit");
    brk_ie = 2'b00;
    step(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 0, 8'h60, 8'h00, 2'b00, 2'b00, "R2 break masked");
    brk_ie = 2'b01; brk_stat = 2'b01;
    step(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1, 8'h60, 8'h08, 2'b00, 2'b00, "R9 break A ext bit");
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule